// File: doc/BRIEF.md
# Key-Protected Escalating Watchdog

This block is a watchdog countdown with two stages of escalation. Software arms and services it through a single control word. Once the watchdog is enabled, a new control word is taken only if its key field is the bitwise inverse of the key already stored. A stray or runaway write therefore cannot re-arm the watchdog or silence it. Each accepted write reloads the countdown and either runs it or halts it.

The countdown moves only on cycles where a slow tick-enable input is high. When it runs out the first time, the block raises a non-maskable interrupt level and starts a short grace countdown. If software does not service the watchdog before the grace countdown also runs out, the block sends a one-cycle system reset request and stops. A status word can be read back; it holds the live count, the run state and the interrupt level.

Top module: `key_watchdog`

## Requirements
- R1: After synchronous reset, `nmi` and `rst_req` are 0, the countdown is halted, and the status word reads 0.
- R2: When the stored enable bit (control bit 8) is 1, a control write is ignored completely if its key (bits [15:9]) is not the 7-bit inverse of the stored key. Count, run state, stored key and `nmi` are all left unchanged.
- R3: When the stored enable bit is 0, a control write is accepted whatever its key.
- R4: On an accepted write, the count field (bits [7:0]) is loaded as the new count. A field of 0 loads 256.
- R5: On an accepted write, bit 8 = 1 runs the countdown and bit 8 = 0 halts it. A halted count does not change on tick cycles. The written word becomes the stored control word.
- R6: A running count goes down by one only on cycles with `tick` high. It holds on all other cycles.
- R7: A tick that finds the count at 1, with `nmi` low, sets `nmi` and loads GRACE_TICKS (default 10). The countdown keeps running.
- R8: A tick that finds the count at 1, with `nmi` already high, gives `rst_req` high for exactly one cycle, halts the countdown and leaves the count at 0.
- R9: An accepted write clears `nmi`. It takes priority over a tick in the same cycle.
- R10: A read of the control offset (0x40) returns 0. A read of the status offset (0x44) returns the count in bits [8:0], the run state in bit 9 and `nmi` in bit 10, with all other bits 0.
- R11: A write to any offset other than 0x40 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow countdown enable, one cycle per tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| nmi | output | 1 | Non-maskable interrupt level after first expiry |
| rst_req | output | 1 | One-cycle system reset request after second expiry |

## Verification
A wrong stored key shows up at once: the next properly keyed write is refused, and the status word then keeps its old count and run bit. A wrong count or run state appears in the status word on the cycle after the tick or write that caused it. The bench compares status, `nmi` and `rst_req` with a behavioural model on every cycle. An escalation fault therefore shows as an early or missing `nmi` edge, or an extra or missing `rst_req` pulse, on exactly the tick where the count reaches its end.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int FIELD_W = 8;
    localparam int KEY_W   = 7;
    localparam int CNT_W   = FIELD_W + 1;
    localparam int CTRL_W  = KEY_W + 1 + FIELD_W;

    typedef struct packed {
        logic [KEY_W-1:0]   key;
        logic               run;
        logic [FIELD_W-1:0] cnt;
    } wd_ctrl_t;

    function automatic logic [CNT_W-1:0] load_value(input logic [FIELD_W-1:0] f);
        return (f == '0) ? CNT_W'(1 << FIELD_W) : {1'b0, f};
    endfunction

    function automatic logic key_matches(input logic [KEY_W-1:0] stored,
                                         input logic [KEY_W-1:0] offered);
        return offered == ~stored;
    endfunction
endpackage

// File: rtl/wd_key_gate.sv
module wd_key_gate
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_ctrl,
    input  wd_ctrl_t wr_word,
    output logic     accept,
    output wd_ctrl_t ctrl_q
);
    always_comb begin
        accept = wr_ctrl && (!ctrl_q.run || key_matches(ctrl_q.key, wr_word.key));
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (accept)
            ctrl_q <= wr_word;
    end

    // R2: a refused write leaves the stored word as it was
    a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_q.run && wr_word.key != ~ctrl_q.key) |=> $stable(ctrl_q));
    // R3: a disabled watchdog takes any key
    a_r3_open_write_taken: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ctrl_q.run) |=> (ctrl_q == $past(wr_word)));
endmodule

// File: rtl/wd_countdown.sv
module wd_countdown
    import wdt_pkg::*;
#(
    parameter int GRACE_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  wd_ctrl_t         load_word,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             nmi_q,
    output logic             rst_req_q
);
    localparam logic [CNT_W-1:0] GRACE = CNT_W'(GRACE_TICKS);

    typedef enum logic [1:0] {EV_NONE, EV_STEP, EV_FIRST, EV_FINAL} wd_event_e;
    wd_event_e ev;

    always_comb begin
        ev = EV_NONE;
        if (tick && run_q) begin
            if (cnt_q > CNT_W'(1))
                ev = EV_STEP;
            else if (!nmi_q)
                ev = EV_FIRST;
            else
                ev = EV_FINAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            run_q     <= 1'b0;
            nmi_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (load) begin
                cnt_q <= load_value(load_word.cnt);
                run_q <= load_word.run;
                nmi_q <= 1'b0;
            end else begin
                case (ev)
                    EV_STEP:  cnt_q <= cnt_q - CNT_W'(1);
                    EV_FIRST: begin
                        cnt_q <= GRACE;
                        nmi_q <= 1'b1;
                    end
                    EV_FINAL: begin
                        cnt_q     <= '0;
                        run_q     <= 1'b0;
                        rst_req_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: count holds without a tick or a load
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
    // R7: interrupt rises together with the grace reload
    a_r7_nmi_with_grace: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_q) |-> (cnt_q == GRACE && run_q));
    // R8: reset request is a single cycle and follows the interrupt stage
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q);
    a_r8_after_nmi: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |-> (nmi_q && !run_q));
    // R9: accepted write clears the interrupt
    a_r9_load_clears_nmi: assert property (@(posedge clk) disable iff (rst)
        load |=> !nmi_q);
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CTRL_OFS    = 'h40,
    parameter int STAT_OFS    = 'h44,
    parameter int GRACE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              nmi,
    output logic              rst_req
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic             wr_ctrl;
    logic             accept;
    wd_ctrl_t         wr_word;
    wd_ctrl_t         ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign wr_word = wd_ctrl_t'(wr_data[CTRL_W-1:0]);

    wd_key_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wr_word (wr_word),
        .accept  (accept),
        .ctrl_q  (ctrl_q)
    );

    wd_countdown #(.GRACE_TICKS(GRACE_TICKS)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (accept),
        .load_word (wr_word),
        .cnt_q     (cnt_q),
        .run_q     (run_q),
        .nmi_q     (nmi),
        .rst_req_q (rst_req)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STAT)
            rd_data = DATA_W'({nmi, run_q, cnt_q});
    end

    // R11: writes elsewhere never reach the gate
    a_r11_other_offset_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != A_CTRL) |=> $stable(ctrl_q));
    // R10: control offset reads as zero
    a_r10_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CTRL) |-> (rd_data == '0));
endmodule

// File: tb/key_watchdog_tb.sv
module key_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GRACE = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h44;
    logic [31:0] rd_data;
    logic        nmi, rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // behavioural model state
    int m_ctrl = 0, m_cnt = 0, m_run = 0, m_nmi = 0, m_rst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_watchdog #(.GRACE_TICKS(GRACE)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .nmi(nmi), .rst_req(rst_req)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_read();
        if (rd_addr == 8'h44) return m_cnt | (m_run << 9) | (m_nmi << 10);
        return 0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_run = 0; m_nmi = 0; m_rst = 0;
        end else begin
            m_rst = 0;
            if (wr_en && wr_addr == 8'h40 &&
                (((m_ctrl >> 8) & 1) == 0 ||
                 ((wr_data >> 9) & 'h7f) == ((~(m_ctrl >> 9)) & 'h7f))) begin
                m_cnt  = ((wr_data & 'hff) == 0) ? 256 : (wr_data & 'hff);
                m_run  = (wr_data >> 8) & 1;
                m_ctrl = wr_data & 'hffff;
                m_nmi  = 0;
            end else if (tick && m_run == 1) begin
                if (m_cnt > 1) m_cnt = m_cnt - 1;
                else if (m_nmi == 0) begin m_nmi = 1; m_cnt = GRACE; end
                else begin m_rst = 1; m_run = 0; m_cnt = 0; end
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check(rd_data == 32'(model_read()), "R6 model rd_data", rd_data, model_read());
            check(nmi == m_nmi[0], "R7 model nmi", nmi, m_nmi);
            check(rst_req == m_rst[0], "R8 model rst_req", rst_req, m_rst);
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        #2;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
        end
        tick = 1'b0;
        #2;
    endtask

    task automatic expect_stat(input int exp, input string req);
        check(rd_data == 32'(exp), req, rd_data, exp);
    endtask

    initial begin
        step(); step();
        rst = 1'b0;
        #2;
        // R1 reset state
        expect_stat(0, "R1 status after reset");
        check(nmi == 0 && rst_req == 0, "R1 outputs after reset", {nmi, rst_req}, 0);

        wr(8'h40, 32'h2B05);                  // R3 open: key 0x15 run count 5
        expect_stat('h205, "R3 first write taken");
        ticks(2);
        expect_stat('h203, "R6 two ticks");
        step(); step(); step(); #2;
        expect_stat('h203, "R6 hold without tick");

        wr(8'h40, 32'h2B64);                  // same key again: refused
        expect_stat('h203, "R2 wrong key ignored");

        wr(8'h40, 32'hD500);                  // key 0x6A, count 0
        expect_stat('h300, "R4 zero field loads 256");

        wr(8'h40, 32'h2A07);                  // key 0x15, halt, count 7
        expect_stat('h007, "R5 halt loaded");
        ticks(3);
        expect_stat('h007, "R5 halted ignores ticks");

        wr(8'h40, 32'h6702);                  // disabled: any key, run count 2
        expect_stat('h202, "R3 unlocked any key");
        ticks(1);
        expect_stat('h201, "R6 step");
        ticks(1);
        check(nmi == 1, "R7 nmi raised", nmi, 1);
        expect_stat('h60A, "R7 grace loaded");

        wr(8'h40, 32'h9903);                  // key 0x4C run count 3
        check(nmi == 0, "R9 nmi cleared", nmi, 0);
        expect_stat('h203, "R9 status after service");

        ticks(3);
        expect_stat('h60A, "R7 second first-expiry");
        ticks(9);
        expect_stat('h601, "R6 grace count");
        check(rst_req == 0, "R8 no early request", rst_req, 0);
        tick = 1'b1; step(); tick = 1'b0; #2;
        check(rst_req == 1, "R8 request raised", rst_req, 1);
        expect_stat('h400, "R8 halted at zero");
        step(); #2;
        check(rst_req == 0, "R8 pulse one cycle", rst_req, 0);

        rd_addr = 8'h40; #1;
        check(rd_data == 0, "R10 control reads zero", rd_data, 0);
        rd_addr = 8'h44;
        wr(8'h48, 32'h6705);
        expect_stat('h400, "R11 other offset ignored");
        check(nmi == 1, "R11 nmi unchanged", nmi, 1);

        step(); step();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule